// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder that adds two operands and a carry-in, and returns a sum and a carry-out. The word is split into carry-select groups. The groups get wider toward the most significant end, so that the time a group needs to form its local results roughly matches the time the selected carry takes to reach it.

The least significant group is a plain ripple adder that takes the external carry-in directly. Every other group computes two candidate results: one for an incoming carry of 0 and one for an incoming carry of 1.
- The carry-0 candidate comes from a ripple chain.
- The carry-1 candidate reuses that chain's per-bit propagate and generate terms instead of a second full adder chain. Its lowest sum bit is the inverted propagate, and its lowest candidate carry is the OR of the two operand bits.
- A per-group two-way multiplexer, steered by the carry arriving at the group, picks one candidate.

The selected carry-out of each group steers the next group.

A 16-bit segment uses groups of 2, 2, 3, 4 and 5 bits. An 8-bit build uses three groups of 2, 2 and 4 bits. A 32-bit build chains two 16-bit segments, with the lower segment's carry-out feeding the upper segment's carry-in. The width parameter accepts only 8, 16 and 32.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For WIDTH = 8, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every operand and carry-in combination.
- R2: For WIDTH = 16 and WIDTH = 32, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for any operands and carry-in.
- R3: In every selecting group, the carry-1 candidate (carry and sum together) equals the carry-0 candidate plus one. The carry-0 candidate carry never exceeds the carry-1 candidate carry.
- R4: A carry entering the lowest group propagates through every group boundary. All-ones plus zero with carry-in 1 gives a zero sum and a carry-out of 1.
- R5: For WIDTH = 32, a carry leaving bit 15 enters bit 16. For example, 0x0000FFFF + 0 + 1 gives 0x00010000 with carry-out 0.
- R6: Zero operands with carry-in 0 give a zero sum and a zero carry-out.
- R7: `cout_o` is 1 exactly when the true total exceeds 2^WIDTH - 1. All-ones plus all-ones with carry-in 1 gives an all-ones sum and carry-out 1.
- R8: The external carry-in adds into bit 0 with no other effect. Zero operands with carry-in 1 give a sum of 1 and a carry-out of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
A wrong carry-1 candidate inside a group stays hidden until that group's incoming carry is 1. It then shows at the ports at once as a sum that is off by a multiple of that group's base weight. A mis-wired select or a dropped inter-group carry shows as a sum error at the first bit of the next group. These faults need carry-chain stimulus to appear: all-ones operands, the boundary case between the two 32-bit segments, and the full 8-bit sweep that drives every carry pattern into every group.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Per-bit shared terms reused by both candidate paths.
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    // Number of carry-select groups in one segment.
    function automatic int grp_count(input int seg_w);
        return (seg_w == 8) ? 3 : 5;
    endfunction

    // Width of group k in a segment of width seg_w (k = 0 is least significant).
    function automatic int grp_width(input int seg_w, input int k);
        int w;
        if (seg_w == 8) begin
            case (k)
                0: w = 2;
                1: w = 2;
                default: w = 4;
            endcase
        end else begin
            case (k)
                0: w = 2;
                1: w = 2;
                2: w = 3;
                3: w = 4;
                default: w = 5;
            endcase
        end
        return w;
    endfunction

    // Bit position where group k starts.
    function automatic int grp_base(input int seg_w, input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += grp_width(seg_w, i);
        return acc;
    endfunction

    function automatic bit width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/csa_ripple_grp.sv
module csa_ripple_grp
    import csa_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    always_comb begin
        chain[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            sum_o[i]    = a_i[i] ^ b_i[i] ^ chain[i];
            chain[i+1]  = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & chain[i]);
        end
        cout_o = chain[W];
    end

    always_comb begin
        AST_LOW_GROUP_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i))) // R8
            else $error("lowest group result wrong");
    end

endmodule

// File: rtl/csa_select_grp.sv
module csa_select_grp
    import csa_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         csel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    pg_t [W-1:0] pg;
    logic [W:0]  c0;
    logic [W:0]  c1;
    logic [W-1:0] s0;
    logic [W-1:0] s1;

    // Shared propagate/generate terms.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            pg[i].prop = a_i[i] ^ b_i[i];
            pg[i].gen  = a_i[i] & b_i[i];
        end
    end

    // Carry-0 candidate: ordinary ripple from a zero carry.
    always_comb begin
        c0[0] = 1'b0;
        for (int i = 0; i < W; i++) begin
            s0[i]   = pg[i].prop ^ c0[i];
            c0[i+1] = pg[i].gen | (pg[i].prop & c0[i]);
        end
    end

    // Carry-1 candidate built from the shared terms: bit 0 is the inverted
    // propagate with an OR carry; higher bits ripple the candidate carry.
    always_comb begin
        c1[0] = 1'b1;
        s1[0] = ~pg[0].prop;
        c1[1] = a_i[0] | b_i[0];
        for (int i = 1; i < W; i++) begin
            s1[i]   = pg[i].prop ^ c1[i];
            c1[i+1] = pg[i].gen | (pg[i].prop & c1[i]);
        end
    end

    // Selection by the real incoming carry.
    always_comb begin
        if (csel_i) begin
            sum_o  = s1;
            cout_o = c1[W];
        end else begin
            sum_o  = s0;
            cout_o = c0[W];
        end
    end

    always_comb begin
        AST_ALT_IS_INCREMENT: assert ({c1[W], s1} == ({c0[W], s0} + (W+1)'(1))) // R3
            else $error("carry-1 candidate is not carry-0 candidate plus one");
        AST_CARRY_ORDER: assert (!c0[W] || c1[W]) // R3
            else $error("carry-0 candidate carry above carry-1 candidate carry");
    end

endmodule

// File: rtl/csa_segment.sv
module csa_segment
    import csa_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             cin_i,
    output logic [SEG_W-1:0] sum_o,
    output logic             cout_o
);

    localparam int NGRP = grp_count(SEG_W);

    logic [NGRP:0] gcar;

    assign gcar[0] = cin_i;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int GW = grp_width(SEG_W, k);
        localparam int GB = grp_base(SEG_W, k);
        if (k == 0) begin : g_low
            csa_ripple_grp #(.W(GW)) u_rip (
                .a_i   (a_i[GB +: GW]),
                .b_i   (b_i[GB +: GW]),
                .cin_i (gcar[k]),
                .sum_o (sum_o[GB +: GW]),
                .cout_o(gcar[k+1])
            );
        end else begin : g_sel
            csa_select_grp #(.W(GW)) u_sel (
                .a_i   (a_i[GB +: GW]),
                .b_i   (b_i[GB +: GW]),
                .csel_i(gcar[k]),
                .sum_o (sum_o[GB +: GW]),
                .cout_o(gcar[k+1])
            );
        end
    end

    assign cout_o = gcar[NGRP];

    always_comb begin
        AST_SEGMENT_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (SEG_W+1)'(cin_i))) // R4
            else $error("segment result wrong");
    end

endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder
    import csa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int SEG_W = (WIDTH == 8) ? 8 : 16;
    localparam int NSEG  = WIDTH / SEG_W;

    if (!width_ok(WIDTH)) begin : g_bad_width
        $error("csa_sqrt_adder: WIDTH must be 8, 16 or 32");
    end

    logic [NSEG:0] scar;

    assign scar[0] = cin_i;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        csa_segment #(.SEG_W(SEG_W)) u_seg (
            .a_i   (a_i[s*SEG_W +: SEG_W]),
            .b_i   (b_i[s*SEG_W +: SEG_W]),
            .cin_i (scar[s]),
            .sum_o (sum_o[s*SEG_W +: SEG_W]),
            .cout_o(scar[s+1])
        );
    end

    assign cout_o = scar[NSEG];

    always_comb begin
        AST_TOTAL_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i))) // R2
            else $error("adder result wrong");
        AST_ZERO_IN_ZERO_OUT: assert (!((a_i == '0) && (b_i == '0) && !cin_i) || ((sum_o == '0) && !cout_o)) // R6
            else $error("zero inputs gave nonzero output");
    end

endmodule

// File: tb/tb_csa_sqrt_adder.sv
module tb_csa_sqrt_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0]  a8,  b8,  s8;
    logic [15:0] a16, b16, s16;
    logic [31:0] a32, b32, s32;
    logic        ci8, ci16, ci32, co8, co16, co32;

    csa_sqrt_adder #(.WIDTH(8))  dut_w8  (.a_i(a8),  .b_i(b8),  .cin_i(ci8),  .sum_o(s8),  .cout_o(co8));
    csa_sqrt_adder #(.WIDTH(16)) dut     (.a_i(a16), .b_i(b16), .cin_i(ci16), .sum_o(s16), .cout_o(co16));
    csa_sqrt_adder #(.WIDTH(32)) dut_w32 (.a_i(a32), .b_i(b32), .cin_i(ci32), .sum_o(s32), .cout_o(co32));

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
        a8 = a; b8 = b; ci8 = c; #1;
    endtask
    task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c);
        a16 = a; b16 = b; ci16 = c; #1;
    endtask
    task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
        a32 = a; b32 = b; ci32 = c; #1;
    endtask

    function automatic logic [32:0] ref_sum(input logic [31:0] a, input logic [31:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + 33'(c);
    endfunction

    initial begin
        a8 = '0; b8 = '0; ci8 = 1'b0;
        a16 = '0; b16 = '0; ci16 = 1'b0;
        a32 = '0; b32 = '0; ci32 = 1'b0;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6: reset state, zero inputs
        chk("R6 w8",  {24'b0, co8,  s8},  33'd0);
        chk("R6 w16", {16'b0, co16, s16}, 33'd0);
        chk("R6 w32", {co32, s32},        33'd0);

        // R8: carry-in alone
        drive8(8'h00, 8'h00, 1'b1);   chk("R8 w8",  {24'b0, co8, s8},   33'd1);
        drive16(16'h0, 16'h0, 1'b1);  chk("R8 w16", {16'b0, co16, s16}, 33'd1);
        drive32(32'h0, 32'h0, 1'b1);  chk("R8 w32", {co32, s32},        33'd1);

        // R4: carry ripples through every group boundary
        drive8(8'hFF, 8'h00, 1'b1);       chk("R4 w8",  {24'b0, co8, s8},   {24'b0, 9'h100});
        drive16(16'hFFFF, 16'h0, 1'b1);   chk("R4 w16", {16'b0, co16, s16}, {16'b0, 17'h10000});
        drive32(32'hFFFFFFFF, 32'h0, 1'b1); chk("R4 w32", {co32, s32},      {1'b1, 32'h0});

        // R7: maximal total
        drive8(8'hFF, 8'hFF, 1'b1);     chk("R7 w8",  {24'b0, co8, s8},   {24'b0, 9'h1FF});
        drive16(16'hFFFF, 16'hFFFF, 1'b1); chk("R7 w16", {16'b0, co16, s16}, {16'b0, 17'h1FFFF});
        drive32(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1); chk("R7 w32", {co32, s32}, {1'b1, 32'hFFFFFFFF});
        drive16(16'h8000, 16'h7FFF, 1'b0); chk("R7 no carry w16", {16'b0, co16, s16}, {16'b0, 17'h0FFFF});

        // R5: carry between the two 32-bit segments
        drive32(32'h0000FFFF, 32'h0, 1'b1); chk("R5 seam", {co32, s32}, {1'b0, 32'h00010000});
        drive32(32'h00008000, 32'h00008000, 1'b0); chk("R5 seam gen", {co32, s32}, {1'b0, 32'h00010000});
        drive32(32'hFFFF0000, 32'h0000FFFF, 1'b1); chk("R5 full chain", {co32, s32}, {1'b1, 32'h0});

        // R1: exhaustive 8-bit sweep
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++) begin
                    drive8(8'(a), 8'(b), 1'(c));
                    chk("R1", {24'b0, co8, s8}, ref_sum(32'(a), 32'(b), 1'(c)));
                end

        // R2 and R3: random vectors on the wide builds (R3 checked by group assertions)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            logic        rc;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            drive16(ra[15:0], rb[15:0], rc);
            chk("R2 w16", {16'b0, co16, s16}, ref_sum({16'b0, ra[15:0]}, {16'b0, rb[15:0]}, rc));
            drive32(ra, rb, rc);
            chk("R2 w32", {co32, s32}, ref_sum(ra, rb, rc));
        end

        // R3: group-boundary carry patterns on the 16-bit build
        for (int k = 0; k < 16; k++) begin
            logic [15:0] m;
            m = 16'((32'h1 << k) - 1);
            drive16(m, 16'h0, 1'b1);
            chk("R3 boundary", {16'b0, co16, s16}, ref_sum({16'b0, m}, 32'h0, 1'b1));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule